// File: doc/BRIEF.md
# Multi-channel conversion result bank with two-level overrun tracking

This block stores the results of a multi-channel analog-to-digital converter and the status flags that go with them. A conversion sequencer hands over each finished result on a valid/ready stream as a channel index, a result word and a drop marker. An accepted result is written into that channel's own data register and into one shared latest-result register. It also sets the channel's end-of-conversion flag and a global data-ready flag.

Overrun is tracked at two levels. A channel flags overrun when a new result lands on a channel whose previous result was never read. The global overrun flag is raised when any result lands while the latest-result register is still unread. Software reads through a plain strobe-and-address port. Reading a channel register clears that channel's end-of-conversion flag. Reading the latest-result register clears data-ready. Reading the status word clears every overrun flag. When an overrun event and its clearing read fall in the same cycle, the event wins.

The stream never applies back-pressure: `conv_ready` is held high, and a beat counts as transferred in every cycle in which `conv_valid` is high. The sequencer raises `conv_drop` with a beat when the channel was disabled during that conversion. The block then discards the beat completely.

Top module: `adc_result_bank`

## Requirements
- R1: After a synchronous active-high reset, every channel register, the latest-result register and all flags read as zero.
- R2: An accepted beat (`conv_valid` high, `conv_drop` low) writes `conv_result` into the data register of channel `conv_ch` and into the latest-result register, and sets that channel's end-of-conversion flag and the data-ready flag, all at the next clock edge.
- R3: An accepted beat for a channel whose end-of-conversion flag is set sets that channel's overrun flag and overwrites its data, unless the same cycle is also reading that channel's register.
- R4: An accepted beat while data-ready is set sets the global overrun flag, unless the same cycle is also reading the latest-result register.
- R5: A read at address i (0 to N_CH-1) returns channel i's result, zero-extended. It clears that channel's end-of-conversion flag unless a new result for the channel arrives in the same cycle. It leaves the overrun flags unchanged.
- R6: A read at address N_CH (8) returns the latest result, zero-extended. It clears data-ready unless an accepted beat arrives in the same cycle.
- R7: A read at address N_CH+1 (9) returns the status word. Bits 7:0 hold the end-of-conversion flags (bit i for channel i), bits 15:8 hold the channel overrun flags, bit 16 holds data-ready and bit 17 holds global overrun. The read clears all overrun flags and leaves the end-of-conversion and data-ready flags unchanged.
- R8: If a status read falls in the same cycle as an event that sets an overrun flag, that flag is set after the edge.
- R9: A beat with `conv_drop` high changes no register and no flag.
- R10: `conv_ready` is high whenever reset is low. A read at any address above N_CH+1 returns zero and has no side effect.
- R11: `rd_data` follows the address combinationally in the cycle of `rd_en`. It shows the state before that cycle's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_valid | input | 1 | Result beat present |
| conv_ready | output | 1 | Beat accepted; always high outside reset |
| conv_ch | input | 3 | Channel index of the beat |
| conv_result | input | 10 | Conversion result |
| conv_drop | input | 1 | Discard this beat (channel disabled mid-conversion) |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 4 | Read address: channels 0-7, latest 8, status 9 |
| rd_data | output | 18 | Read data, combinational |

## Verification
Assertions inside each channel slice check on every cycle that accepted beats capture their data and set end-of-conversion, and that a beat landing on unread data raises channel overrun. They also check that dropped beats leave the data register unchanged. Assertions in the global slice check the global overrun set rule, the clearing of data-ready and the rule that an event wins over a clearing status read. An assertion at the top checks that unmapped reads return zero. Only the bench scenarios show the exact bit layout of the status word, which value a coincident read returns, and that a status read leaves end-of-conversion and data-ready alone.

// File: rtl/adc_rb_pkg.sv
package adc_rb_pkg;

  typedef enum logic [1:0] {
    RK_NONE = 2'd0,
    RK_CHAN = 2'd1,
    RK_LAST = 2'd2,
    RK_STAT = 2'd3
  } rd_kind_e;

  // Address map: channels first, then latest result, then status.
  function automatic rd_kind_e decode_addr(input int unsigned addr, input int unsigned n_ch);
    if (addr < n_ch)            return RK_CHAN;
    else if (addr == n_ch)      return RK_LAST;
    else if (addr == n_ch + 1)  return RK_STAT;
    else                        return RK_NONE;
  endfunction

endpackage

// File: rtl/adc_rb_channel.sv
module adc_rb_channel #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [RES_W-1:0] din,
  input  logic             rd_hit,
  input  logic             stat_clr,
  output logic [RES_W-1:0] data_q,
  output logic             eoc_q,
  output logic             ovr_q
);

  logic ovr_event;
  assign ovr_event = wr && eoc_q && !rd_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      eoc_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (wr) data_q <= din;

      if (wr)          eoc_q <= 1'b1;
      else if (rd_hit) eoc_q <= 1'b0;

      if (ovr_event)     ovr_q <= 1'b1;
      else if (stat_clr) ovr_q <= 1'b0;
    end
  end

  p_capture_r2: assert property (@(posedge clk) disable iff (rst)
    wr |=> (data_q == $past(din)));

  p_eoc_set_r2: assert property (@(posedge clk) disable iff (rst)
    wr |=> eoc_q);

  p_ovr_set_r3: assert property (@(posedge clk) disable iff (rst)
    (wr && eoc_q && !rd_hit) |=> ovr_q);

  p_eoc_clr_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && !wr) |=> !eoc_q);

  p_ovr_keep_r8: assert property (@(posedge clk) disable iff (rst)
    (stat_clr && wr && eoc_q && !rd_hit) |=> ovr_q);

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !wr |=> (data_q == $past(data_q)));

endmodule

// File: rtl/adc_rb_global.sv
module adc_rb_global #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [RES_W-1:0] din,
  input  logic             rd_last,
  input  logic             stat_clr,
  output logic [RES_W-1:0] last_q,
  output logic             drdy_q,
  output logic             govr_q
);

  logic govr_event;
  assign govr_event = wr && drdy_q && !rd_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= '0;
      drdy_q <= 1'b0;
      govr_q <= 1'b0;
    end else begin
      if (wr) last_q <= din;

      if (wr)           drdy_q <= 1'b1;
      else if (rd_last) drdy_q <= 1'b0;

      if (govr_event)    govr_q <= 1'b1;
      else if (stat_clr) govr_q <= 1'b0;
    end
  end

  p_last_capture_r2: assert property (@(posedge clk) disable iff (rst)
    wr |=> (drdy_q && last_q == $past(din)));

  p_govr_set_r4: assert property (@(posedge clk) disable iff (rst)
    (wr && drdy_q && !rd_last) |=> govr_q);

  p_drdy_clr_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_last && !wr) |=> !drdy_q);

  p_govr_keep_r8: assert property (@(posedge clk) disable iff (rst)
    (stat_clr && wr && drdy_q && !rd_last) |=> govr_q);

  p_last_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !wr |=> (last_q == $past(last_q)));

endmodule

// File: rtl/adc_rb_readmux.sv
module adc_rb_readmux
  import adc_rb_pkg::*;
#(
  parameter int N_CH   = 8,
  parameter int RES_W  = 10,
  parameter int STAT_W = 18,
  parameter int RD_W   = 18,
  parameter int ADDR_W = 4
) (
  input  rd_kind_e                      kind,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [N_CH-1:0][RES_W-1:0]    chan_data,
  input  logic [RES_W-1:0]              last_data,
  input  logic [STAT_W-1:0]             status,
  output logic [RD_W-1:0]               rd_data
);

  always_comb begin
    rd_data = '0;
    unique case (kind)
      RK_CHAN: begin
        for (int i = 0; i < N_CH; i++) begin
          if (addr == ADDR_W'(i)) rd_data = RD_W'(chan_data[i]);
        end
      end
      RK_LAST: rd_data = RD_W'(last_data);
      RK_STAT: rd_data = RD_W'(status);
      default: rd_data = '0;
    endcase
  end

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
  import adc_rb_pkg::*;
#(
  parameter  int N_CH   = 8,
  parameter  int RES_W  = 10,
  localparam int STAT_W = 2 * N_CH + 2,
  localparam int RD_W   = (STAT_W > RES_W) ? STAT_W : RES_W,
  localparam int ADDR_W = $clog2(N_CH + 2),
  localparam int CH_W   = $clog2(N_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_valid,
  output logic              conv_ready,
  input  logic [CH_W-1:0]   conv_ch,
  input  logic [RES_W-1:0]  conv_result,
  input  logic              conv_drop,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [RD_W-1:0]   rd_data
);

  localparam int OVR_LO  = N_CH;
  localparam int DRDY_B  = 2 * N_CH;
  localparam int GOVR_B  = 2 * N_CH + 1;

  rd_kind_e                   kind;
  logic                       accept;
  logic                       rd_last;
  logic                       stat_clr;
  logic [N_CH-1:0]            eoc_vec;
  logic [N_CH-1:0]            ovr_vec;
  logic [N_CH-1:0][RES_W-1:0] chan_data;
  logic [RES_W-1:0]           last_data;
  logic                       drdy;
  logic                       govr;
  logic [STAT_W-1:0]          status;

  assign conv_ready = !rst;
  assign accept     = conv_valid && conv_ready && !conv_drop;
  assign kind       = rd_en ? decode_addr(int'(rd_addr), N_CH) : RK_NONE;
  assign rd_last    = (kind == RK_LAST);
  assign stat_clr   = (kind == RK_STAT);

  for (genvar g = 0; g < N_CH; g++) begin : g_chan
    logic wr_g;
    logic rd_g;
    assign wr_g = accept && (conv_ch == CH_W'(g));
    assign rd_g = (kind == RK_CHAN) && (rd_addr == ADDR_W'(g));

    adc_rb_channel #(.RES_W(RES_W)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .wr       (wr_g),
      .din      (conv_result),
      .rd_hit   (rd_g),
      .stat_clr (stat_clr),
      .data_q   (chan_data[g]),
      .eoc_q    (eoc_vec[g]),
      .ovr_q    (ovr_vec[g])
    );
  end

  adc_rb_global #(.RES_W(RES_W)) u_global (
    .clk      (clk),
    .rst      (rst),
    .wr       (accept),
    .din      (conv_result),
    .rd_last  (rd_last),
    .stat_clr (stat_clr),
    .last_q   (last_data),
    .drdy_q   (drdy),
    .govr_q   (govr)
  );

  always_comb begin
    status                       = '0;
    status[N_CH-1:0]             = eoc_vec;
    status[OVR_LO +: N_CH]       = ovr_vec;
    status[DRDY_B]               = drdy;
    status[GOVR_B]               = govr;
  end

  adc_rb_readmux #(
    .N_CH   (N_CH),
    .RES_W  (RES_W),
    .STAT_W (STAT_W),
    .RD_W   (RD_W),
    .ADDR_W (ADDR_W)
  ) u_rmux (
    .kind      (kind),
    .addr      (rd_addr),
    .chan_data (chan_data),
    .last_data (last_data),
    .status    (status),
    .rd_data   (rd_data)
  );

  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && int'(rd_addr) > N_CH + 1) |-> (rd_data == '0));

  p_ready_r10: assert property (@(posedge clk) disable iff (rst)
    conv_valid |-> conv_ready);

endmodule

// File: tb/test_adc_result_bank.sv
module test_adc_result_bank;

  logic        clk = 1'b0;
  logic        rst;
  logic        conv_valid;
  logic        conv_ready;
  logic [2:0]  conv_ch;
  logic [9:0]  conv_result;
  logic        conv_drop;
  logic        rd_en;
  logic [3:0]  rd_addr;
  logic [17:0] rd_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  localparam logic [3:0] A_LAST = 4'd8;
  localparam logic [3:0] A_STAT = 4'd9;

  always #2 clk = ~clk;

  adc_result_bank i_adc_result_bank (
    .clk         (clk),
    .rst         (rst),
    .conv_valid  (conv_valid),
    .conv_ready  (conv_ready),
    .conv_ch     (conv_ch),
    .conv_result (conv_result),
    .conv_drop   (conv_drop),
    .rd_en       (rd_en),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data)
  );

  task automatic chk(input bit ok, input string req, input logic [17:0] act, input logic [17:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%05h expected 0x%05h", req, act, exp);
    end
  endtask

  // One cycle from a negedge: optional beat and optional read; returns rd_data seen before the edge.
  task automatic step(input bit cv, input logic [2:0] ch, input logic [9:0] res, input bit drop,
                      input bit re, input logic [3:0] addr, output logic [17:0] seen);
    conv_valid = cv; conv_ch = ch; conv_result = res; conv_drop = drop;
    rd_en = re; rd_addr = addr;
    #1;
    seen = rd_data;
    if (cv) chk(conv_ready == 1'b1, "R10 ready", 18'(conv_ready), 18'd1);
    @(posedge clk);
    @(negedge clk);
    conv_valid = 1'b0; conv_drop = 1'b0; rd_en = 1'b0;
  endtask

  task automatic conv(input logic [2:0] ch, input logic [9:0] res);
    logic [17:0] d;
    step(1'b1, ch, res, 1'b0, 1'b0, 4'd0, d);
  endtask

  task automatic rd(input logic [3:0] addr, output logic [17:0] v);
    step(1'b0, 3'd0, 10'd0, 1'b0, 1'b1, addr, v);
  endtask

  task automatic t_reset;
    logic [17:0] v;
    rd(A_STAT, v); chk(v == 18'h0, "R1 status", v, 18'h0);
    rd(4'd3, v);   chk(v == 18'h0, "R1 ch3", v, 18'h0);
    rd(A_LAST, v); chk(v == 18'h0, "R1 last", v, 18'h0);
  endtask

  task automatic t_basic;
    logic [17:0] v;
    conv(3'd2, 10'h155);
    rd(A_STAT, v); chk(v == 18'h10004, "R2 status after beat", v, 18'h10004);
    rd(4'd2, v);   chk(v == 18'h155, "R5 R11 ch2 data", v, 18'h155);
    rd(A_LAST, v); chk(v == 18'h155, "R6 last data", v, 18'h155);
    rd(A_STAT, v); chk(v == 18'h0, "R5 R6 flags cleared", v, 18'h0);
  endtask

  task automatic t_chan_overrun;
    logic [17:0] v;
    conv(3'd5, 10'h011);
    conv(3'd5, 10'h022);
    rd(A_STAT, v); chk(v == 18'h32020, "R3 R4 overrun status", v, 18'h32020);
    rd(A_STAT, v); chk(v == 18'h10020, "R7 status read clears overruns only", v, 18'h10020);
    rd(4'd5, v);   chk(v == 18'h022, "R3 data overwritten", v, 18'h022);
    rd(A_LAST, v); chk(v == 18'h022, "R2 last data", v, 18'h022);
    rd(A_STAT, v); chk(v == 18'h0, "R7 clean", v, 18'h0);
  endtask

  task automatic t_global_overrun;
    logic [17:0] v;
    conv(3'd0, 10'h3FF);
    conv(3'd1, 10'h001);
    rd(A_STAT, v); chk(v == 18'h30003, "R4 global overrun only", v, 18'h30003);
    rd(A_STAT, v); chk(v == 18'h10003, "R7 global overrun cleared", v, 18'h10003);
    rd(4'd0, v);   chk(v == 18'h3FF, "R5 ch0 full scale", v, 18'h3FF);
    rd(4'd1, v);
    rd(A_LAST, v); chk(v == 18'h001, "R6 last", v, 18'h001);
  endtask

  task automatic t_read_with_beat;
    logic [17:0] v;
    conv(3'd4, 10'h0AA);
    step(1'b1, 3'd4, 10'h0BB, 1'b0, 1'b1, 4'd4, v);
    chk(v == 18'h0AA, "R11 R5 coincident read old value", v, 18'h0AA);
    rd(A_STAT, v); chk(v == 18'h30010, "R3 R5 no ch overrun, eoc kept", v, 18'h30010);
    rd(4'd4, v);   chk(v == 18'h0BB, "R5 new data", v, 18'h0BB);
    rd(A_LAST, v);
    rd(A_STAT, v); chk(v == 18'h0, "R5 clean", v, 18'h0);
  endtask

  task automatic t_status_vs_event;
    logic [17:0] v;
    conv(3'd6, 10'h100);
    step(1'b1, 3'd6, 10'h101, 1'b0, 1'b1, A_STAT, v);
    chk(v == 18'h10040, "R8 status seen before event", v, 18'h10040);
    rd(A_STAT, v); chk(v == 18'h34040, "R8 overrun survives coincident read", v, 18'h34040);
    rd(A_STAT, v); chk(v == 18'h10040, "R7 cleared on next read", v, 18'h10040);
    rd(4'd6, v);
    rd(A_LAST, v);
  endtask

  task automatic t_drop;
    logic [17:0] v;
    conv(3'd7, 10'h2AA);
    rd(4'd7, v);
    rd(A_LAST, v);
    step(1'b1, 3'd7, 10'h155, 1'b1, 1'b0, 4'd0, v);
    rd(A_STAT, v); chk(v == 18'h0, "R9 no flags after drop", v, 18'h0);
    rd(4'd7, v);   chk(v == 18'h2AA, "R9 channel data kept", v, 18'h2AA);
    rd(A_LAST, v); chk(v == 18'h2AA, "R9 last data kept", v, 18'h2AA);
  endtask

  task automatic t_unmapped;
    logic [17:0] v;
    conv(3'd1, 10'h0F0);
    conv(3'd1, 10'h0F1);
    rd(4'd12, v);  chk(v == 18'h0, "R10 unmapped reads zero", v, 18'h0);
    rd(4'd15, v);  chk(v == 18'h0, "R10 unmapped reads zero", v, 18'h0);
    rd(A_STAT, v); chk(v == 18'h30202, "R10 unmapped no side effect", v, 18'h30202);
    rd(4'd1, v);
    rd(A_LAST, v);
    rd(A_STAT, v);
  endtask

  task automatic t_last_with_beat;
    logic [17:0] v;
    conv(3'd3, 10'h033);
    step(1'b1, 3'd2, 10'h044, 1'b0, 1'b1, A_LAST, v);
    chk(v == 18'h033, "R6 coincident last read old value", v, 18'h033);
    rd(A_STAT, v); chk(v == 18'h1000C, "R6 R4 drdy kept, no global overrun", v, 18'h1000C);
  endtask

  initial begin
    rst = 1'b1; conv_valid = 1'b0; conv_ch = '0; conv_result = '0;
    conv_drop = 1'b0; rd_en = 1'b0; rd_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_chan_overrun();
    t_global_overrun();
    t_read_with_beat();
    t_status_vs_event();
    t_drop();
    t_unmapped();
    t_last_with_beat();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule